// File: doc/BRIEF.md
# Boot Checksum Security Gate

This block stands beside a boot-memory read bus and decides whether a protected peripheral register window may be used. Out of reset it is in the checking state. In that state it adds every data word read over the boot bus into a running wrapping sum. When a read hits the programmed end address, it compares that sum, which includes the word just read, against a constant fixed at build time. A match opens the window. A mismatch locks the block in a failed state that only reset clears.

Software reaches the block through a two-entry register interface, selected by `reg_sel`:

- With `reg_sel` = 0, a write programs the end address. A read of this entry always returns the same fixed pattern.
- With `reg_sel` = 1, a read returns the current state code. This entry is read-only.

In the passed state, a write of the end address re-arms the check. The block then returns to checking with the sum cleared. While the window is closed, its read data is replaced by all ones, so the peripheral behind it gives nothing away.

Top module: `boot_sec_gate`

## Requirements
- R1: After reset the status code is 0 (checking), `win_open` is 0, and the end address is all ones (every bit of `ADDR_W` set).
- R2: In the checking state, each cycle with `snp_valid` high adds `snp_data` into a `SUM_W`-bit sum that wraps on overflow. Cycles with `snp_valid` low add nothing.
- R3: A valid read whose address equals the end address, while the sum plus that read's data equals `EXPECTED_SUM`, moves the block to status 3 (passed). From the clock edge that samples that read, `win_open` is 1.
- R4: A valid read at the end address whose sum (including its own data) differs from `EXPECTED_SUM` moves the block to status 2 (failed).
- R5: In the failed state, end-address writes and snooped reads have no effect. The status stays 2 and the window stays closed until reset.
- R6: While `win_open` is 0, `win_rdata_out` is all ones. While `win_open` is 1, it equals `win_rdata_in`.
- R7: A register read with `reg_sel` = 0 returns 0x000000FF, whatever was written. Read data appears on `reg_rdata` one cycle after `reg_sel` is presented.
- R8: A register read with `reg_sel` = 1 returns the state code in bits [1:0] (0 checking, 2 failed, 3 passed), with all upper bits zero. Writes with `reg_sel` = 1 are ignored.
- R9: In the passed state, a write with `reg_sel` = 0 returns the block to status 0, closes the window, and clears the sum.
- R10: In the checking state, a write with `reg_sel` = 0 replaces the end address (bits [ADDR_W-1:0] of `reg_wdata`). Valid reads at any other address cause no comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | Boot-bus read sample is valid this cycle |
| snp_addr | input | ADDR_W | Word address of the snooped read |
| snp_data | input | SUM_W | Data word of the snooped read |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 end address, 1 status |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Registered register read data |
| win_rdata_in | input | WIN_W | Read data from the protected window |
| win_rdata_out | output | WIN_W | Gated window read data |
| win_open | output | 1 | Window accessible (passed state) |

## Verification
The bench builds the block with an 8-bit address, so the all-ones reset end address (0xFF) can be reached directly without programming. It uses a 32-bit sum against the constant 0x12345678, with one word of 0xFFFFFFFF so that the pass depends on the sum wrapping. The directed runs cover a pass through the reset end address and a pass after an idle gap. They also cover a re-arm whose single word passes only if the sum was cleared, a retargeted end address whose old value must be ignored, and a failure followed by writes and reads that must leave the lock intact until reset.

// File: rtl/boot_sec_pkg.sv
package boot_sec_pkg;

  typedef enum logic [1:0] {
    SEC_CHECKING = 2'd0,
    SEC_FAILED   = 2'd2,
    SEC_PASSED   = 2'd3
  } sec_state_e;

  localparam logic [7:0] END_READBACK = 8'hFF;

endpackage

// File: rtl/boot_sec_endreg.sv
module boot_sec_endreg #(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              hit
);

  localparam logic [ADDR_W-1:0] END_RST = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] end_q;

  always_ff @(posedge clk) begin
    if (rst)        end_q <= END_RST;
    else if (wr_en) end_q <= wr_addr;
  end

  assign hit = snp_valid && (snp_addr == end_q);

  // R1: reset loads the all-ones end address
  a_r1_end_reset: assert property (@(posedge clk) rst |=> end_q == END_RST);

endmodule

// File: rtl/boot_sec_accum.sv
module boot_sec_accum #(
  parameter int              SUM_W        = 32,
  parameter logic [SUM_W-1:0] EXPECTED_SUM = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             add_en,
  input  logic [SUM_W-1:0] data,
  output logic             match
);

  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] sum_inc;

  assign sum_inc = sum_q + data;
  assign match   = (sum_inc == EXPECTED_SUM);

  always_ff @(posedge clk) begin
    if (rst || clear) sum_q <= '0;
    else if (add_en)  sum_q <= sum_inc;
  end

  // R9: a re-arm leaves an empty sum
  a_r9_sum_cleared: assert property (@(posedge clk) disable iff (rst)
    clear |=> sum_q == '0);

  // R2: no valid read, no change to the sum
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!add_en && !clear) |=> $stable(sum_q));

endmodule

// File: rtl/boot_sec_fsm.sv
module boot_sec_fsm
  import boot_sec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       snp_valid,
  input  logic       hit,
  input  logic       match,
  input  logic       wr_end,
  output sec_state_e state_q,
  output logic       add_en,
  output logic       clear,
  output logic       win_open_q
);

  sec_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEC_CHECKING: if (hit) state_d = match ? SEC_PASSED : SEC_FAILED;
      SEC_PASSED:   if (wr_end) state_d = SEC_CHECKING;
      SEC_FAILED:   state_d = SEC_FAILED;
      default:      state_d = SEC_FAILED;
    endcase
  end

  assign add_en = snp_valid && (state_q == SEC_CHECKING);
  assign clear  = wr_end && (state_q == SEC_PASSED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEC_CHECKING;
      win_open_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      win_open_q <= (state_d == SEC_PASSED);
    end
  end

  // R1: reset returns to checking
  a_r1_reset_checking: assert property (@(posedge clk)
    rst |=> (state_q == SEC_CHECKING && !win_open_q));

  // R5: the failed lock is sticky
  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    state_q == SEC_FAILED |=> state_q == SEC_FAILED);

  // R3: end hit with a matching sum passes
  a_r3_pass_on_match: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEC_CHECKING && hit && match) |=> (state_q == SEC_PASSED && win_open_q));

  // R4: end hit with a wrong sum fails
  a_r4_fail_on_mismatch: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEC_CHECKING && hit && !match) |=> state_q == SEC_FAILED);

  // R9: a write in the passed state re-arms
  a_r9_rearm: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEC_PASSED && wr_end) |=> (state_q == SEC_CHECKING && !win_open_q));

  // R6: the gate register tracks the passed state
  a_r6_gate_tracks_state: assert property (@(posedge clk) disable iff (rst)
    win_open_q == (state_q == SEC_PASSED));

endmodule

// File: rtl/boot_sec_regif.sv
module boot_sec_regif
  import boot_sec_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int WIN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_sel,
  input  sec_state_e       state,
  input  logic             win_open,
  input  logic [WIN_W-1:0] win_rdata_in,
  output logic [REG_W-1:0] reg_rdata,
  output logic [WIN_W-1:0] win_rdata_out
);

  localparam logic [WIN_W-1:0] BLOCKED = {WIN_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)          reg_rdata <= '0;
    else if (reg_sel) reg_rdata <= REG_W'(state);
    else              reg_rdata <= REG_W'(END_READBACK);
  end

  assign win_rdata_out = win_open ? win_rdata_in : BLOCKED;

endmodule

// File: rtl/boot_sec_gate.sv
module boot_sec_gate
  import boot_sec_pkg::*;
#(
  parameter int               ADDR_W       = 21,
  parameter int               SUM_W        = 32,
  parameter int               REG_W        = 32,
  parameter int               WIN_W        = 32,
  parameter logic [SUM_W-1:0] EXPECTED_SUM = 32'h1234_5678
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [SUM_W-1:0]  snp_data,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [WIN_W-1:0]  win_rdata_in,
  output logic [WIN_W-1:0]  win_rdata_out,
  output logic              win_open
);

  sec_state_e state;
  logic       wr_end, wr_accept, hit, match, add_en, clear;
  logic       unused_wdata;

  assign wr_end       = reg_wr && !reg_sel;
  assign wr_accept    = wr_end && (state != SEC_FAILED);
  assign unused_wdata = ^reg_wdata;

  boot_sec_endreg #(.ADDR_W(ADDR_W)) endreg_i (
    .clk(clk), .rst(rst), .wr_en(wr_accept), .wr_addr(reg_wdata[ADDR_W-1:0]),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .hit(hit)
  );

  boot_sec_accum #(.SUM_W(SUM_W), .EXPECTED_SUM(EXPECTED_SUM)) accum_i (
    .clk(clk), .rst(rst), .clear(clear), .add_en(add_en),
    .data(snp_data), .match(match)
  );

  boot_sec_fsm fsm_i (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .hit(hit), .match(match),
    .wr_end(wr_end), .state_q(state), .add_en(add_en), .clear(clear),
    .win_open_q(win_open)
  );

  boot_sec_regif #(.REG_W(REG_W), .WIN_W(WIN_W)) regif_i (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .state(state),
    .win_open(win_open), .win_rdata_in(win_rdata_in),
    .reg_rdata(reg_rdata), .win_rdata_out(win_rdata_out)
  );

  // R6: a closed window never leaks peripheral data
  a_r6_blocked_ones: assert property (@(posedge clk) disable iff (rst)
    !win_open |-> win_rdata_out == {WIN_W{1'b1}});

  // R5: writes in the failed state never reopen the window
  a_r5_no_reopen: assert property (@(posedge clk) disable iff (rst)
    (state == SEC_FAILED) |=> !win_open);

endmodule

// File: tb/boot_sec_gate_tb_top.sv
`timescale 1ns/1ps
module boot_sec_gate_tb_top;

  localparam int          AW  = 8;
  localparam logic [31:0] EXP = 32'h1234_5678;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic [31:0]   snp_data = '0;
  logic          reg_wr = 1'b0;
  logic          reg_sel = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [31:0]   win_rdata_in = 32'hA5A5_5A5A;
  logic [31:0]   win_rdata_out;
  logic          win_open;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  boot_sec_gate #(.ADDR_W(AW), .SUM_W(32), .REG_W(32), .WIN_W(32),
                  .EXPECTED_SUM(EXP)) dut_i (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_data(snp_data), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .win_rdata_in(win_rdata_in), .win_rdata_out(win_rdata_out),
    .win_open(win_open)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic snoop(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); snp_valid = 1'b1; snp_addr = a; snp_data = d;
    @(negedge clk); snp_valid = 1'b0; snp_data = 32'hDEAD_0000;
  endtask

  task automatic idle_garbage();
    @(negedge clk); snp_valid = 1'b0; snp_addr = '1; snp_data = 32'h1111_1111;
    @(negedge clk);
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] v);
    @(negedge clk); reg_sel = sel;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic expect_status(input string tag, input logic [1:0] code);
    logic [31:0] v;
    read_reg(1'b1, v);
    check(tag, v, {30'b0, code});
  endtask

  task automatic expect_gate(input string tag, input logic open);
    check({tag, " win_open"}, {31'b0, win_open}, {31'b0, open});
    check({tag, " win data"}, win_rdata_out, open ? win_rdata_in : 32'hFFFF_FFFF);
  endtask

  // R1 R7 R8: reset state and register readback
  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    expect_status("R1 R8 status after reset", 2'd0);
    expect_gate("R1 R6 reset", 1'b0);
    read_reg(1'b0, v);
    check("R7 end address readback", v, 32'h0000_00FF);
  endtask

  // R1 R3: default all-ones end address passes without any write
  task automatic t_default_end();
    do_reset();
    snoop(8'hFF, EXP);
    expect_gate("R1 R3 default end pass", 1'b1);
    expect_status("R3 status passed", 2'd3);
  endtask

  // R2 R3 R10: wrapped sum with an idle gap, end address programmed
  task automatic t_wrap_pass();
    do_reset();
    write_reg(1'b0, 32'h0000_0010);
    snoop(8'h00, 32'hFFFF_FFFF);
    idle_garbage();
    snoop(8'h01, 32'h1234_5679);
    expect_status("R10 no compare off end", 2'd0);
    expect_gate("R10 still blocked", 1'b0);
    snoop(8'h10, 32'h0000_0000);
    expect_gate("R2 R3 wrapped pass", 1'b1);
    win_rdata_in = 32'h0BAD_F00D;
    #1;
    check("R6 open window passes data", win_rdata_out, 32'h0BAD_F00D);
    expect_status("R3 R8 status 3", 2'd3);
  endtask

  // R9 R10: re-arm clears the sum; retarget while checking
  task automatic t_rearm();
    logic [31:0] v;
    write_reg(1'b0, 32'h0000_0020);
    expect_status("R9 re-armed status", 2'd0);
    expect_gate("R9 re-armed blocked", 1'b0);
    snoop(8'h20, EXP);
    expect_gate("R9 sum cleared pass", 1'b1);
    write_reg(1'b0, 32'h0000_0020);
    write_reg(1'b0, 32'h0000_0030);
    read_reg(1'b0, v);
    check("R7 readback after write", v, 32'h0000_00FF);
    snoop(8'h20, 32'h0000_0005);
    expect_status("R10 old end ignored", 2'd0);
    snoop(8'h30, EXP - 32'd5);
    expect_status("R10 new end pass", 2'd3);
  endtask

  // R4 R5 R8: mismatch, sticky failure, only reset leaves
  task automatic t_fail();
    do_reset();
    write_reg(1'b0, 32'h0000_0008);
    write_reg(1'b1, 32'h0000_0003);
    expect_status("R8 status write ignored", 2'd0);
    snoop(8'h08, 32'h0000_0001);
    expect_status("R4 status failed", 2'd2);
    expect_gate("R4 R6 failed blocked", 1'b0);
    write_reg(1'b0, 32'h0000_0009);
    expect_status("R5 write ignored", 2'd2);
    snoop(8'h09, EXP);
    snoop(8'h08, EXP);
    expect_status("R5 reads ignored", 2'd2);
    expect_gate("R5 still blocked", 1'b0);
    do_reset();
    expect_status("R5 reset leaves failed", 2'd0);
    snoop(8'hFF, EXP);
    expect_status("R5 R1 end address back to reset", 2'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_default_end();
    t_wrap_pass();
    t_rearm();
    t_fail();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule